// File: doc/BRIEF.md
# Successive-Approximation Converter Phase Sequencer

This block is the digital timing controller for a successive-approximation analog-to-digital converter running 16-bit single-ended conversions. A one-cycle start request sets off a sequence. The sequence begins with a warm-up interval and then runs one or more acquire/resolve pairs. The block drives three phase strobes that gate the analog macro: warm-up, acquire and resolve. It pulses a completion flag when each result is ready. The analog comparator, the result path and any register access are outside this block.

Most timing runs on a converter clock. An internal prescaler derives this clock from the bus clock, dividing by 1, 2, 4 or 8. Only the first five cycles of warm-up are counted on the bus clock. The configuration is captured when a start is accepted. This covers the high-speed flag, the extended-acquire code, the averaging code and the divider code. A conversion is made of N averaged samples and produces a single completion pulse. In continuous mode the next conversion follows at once, with no warm-up and a shorter first acquire window. The run stops after the conversion during whose final resolve cycle the continuous flag is found low.

Top module: `sar_conv_sequencer`

## Requirements
- R1: While reset is held and after its release with no start, busy, done and all three strobes are 0.
- R2: With D the divisor, N the averaging count, H the high-speed adder and L the extended-acquire adder, busy is high for exactly 5 + D*(5 + N*(25 + H + L)) bus cycles. This gives 35 cycles when D=1, N=1 and H=L=0.
- R3: The first acquire window of a sequence lasts 6 + H + L converter cycles. Every later acquire window, for averaged samples or for continuous conversions, lasts 4 + H + L.
- R4: When hs_en is 1 at start, H = 2; otherwise H = 0. The adder applies to every acquire window.
- R5: lsmp_sel codes 0,1,2,3,4 give L = 0,2,6,12,20 extra converter cycles, and codes 5 to 7 also give 20. L applies to every acquire window.
- R6: avg_sel codes 0,1,2,3,4 give N = 1,4,8,16,32 samples, and codes 5 to 7 also give 32. done pulses once, only after the last sample's resolve phase.
- R7: The warm-up strobe is high for 5 bus cycles plus 3 converter cycles, and only at the start of a sequence. Each resolve phase lasts 21 converter cycles.
- R8: div_sel codes 0,1,2,3 make one converter cycle last 1, 2, 4 or 8 bus cycles.
- R9: A start that arrives while busy is high is ignored. It neither lengthens the current conversion nor queues another.
- R10: With cont_en high, the next conversion's acquire phase begins in the cycle in which done is high, with no warm-up. If cont_en is low during the final resolve cycle, the run ends after that result.
- R11: busy rises in the cycle after an accepted start. When the run ends, busy falls in the same cycle done is high. done is a single-cycle pulse.
- R12: While busy is high, exactly one of the three strobes is high. While it is low, none is.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start | input | 1 | One-cycle request to begin a sequence |
| cont_en | input | 1 | Continuous-run enable, sampled at each conversion end |
| hs_en | input | 1 | High-speed acquire extension, captured at start |
| lsmp_sel | input | 3 | Extended-acquire adder code, captured at start |
| avg_sel | input | 3 | Averaging count code, captured at start |
| div_sel | input | 2 | Converter clock divisor code, captured at start |
| busy | output | 1 | Sequence in progress |
| ph_startup | output | 1 | Warm-up phase strobe |
| ph_sample | output | 1 | Acquire phase strobe |
| ph_convert | output | 1 | Resolve phase strobe |
| done | output | 1 | One-cycle result-ready pulse |

## Verification
The single-conversion timing is swept over every divisor code, both settings of the high-speed flag and every extended-acquire code. In each run the bench measures the total busy time, the warm-up time, the length of the first acquire window, the total acquire time and the total resolve time. Keeping these measurements separate shows whether an error comes from the prescaler, the once-only warm-up, the first-window extension or the per-sample adders. A second sweep over all averaging codes separates the count of averaged samples from the timing of each one, and it confirms that done arrives only once. Directed runs cover three more cases: a start pulse during a conversion, a continuous run that is ended by dropping cont_en, and the shortened acquire window and missing warm-up of back-to-back conversions.

// File: rtl/sar_seq_pkg.sv
// Shared types and code tables for the converter phase sequencer.
// Assumes code widths are fixed at 3 bits for the adder/averaging
// selects and 2 bits for the divisor select.
package sar_seq_pkg;

    localparam int LSMP_SEL_W = 3;
    localparam int AVG_SEL_W  = 3;
    localparam int DIV_SEL_W  = 2;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_SU_BUS,
        ST_SU_ADCK,
        ST_SAMPLE,
        ST_CONVERT
    } seq_state_e;

    typedef struct packed {
        logic                  hs;
        logic [LSMP_SEL_W-1:0] lsmp_sel;
        logic [AVG_SEL_W-1:0]  avg_sel;
        logic [DIV_SEL_W-1:0]  div_sel;
    } seq_cfg_t;

    // Extra acquire cycles for an extended-acquire code.
    function automatic int unsigned lsmp_extra(input logic [LSMP_SEL_W-1:0] code);
        case (code)
            3'd0:    return 0;
            3'd1:    return 2;
            3'd2:    return 6;
            3'd3:    return 12;
            default: return 20;
        endcase
    endfunction

    // Number of averaged samples for an averaging code.
    function automatic int unsigned avg_count(input logic [AVG_SEL_W-1:0] code);
        case (code)
            3'd0:    return 1;
            3'd1:    return 4;
            3'd2:    return 8;
            3'd3:    return 16;
            default: return 32;
        endcase
    endfunction

endpackage

// File: rtl/sar_seq_prescaler.sv
// Converter-clock enable generator.
// Produces a one-bus-cycle tick every 2**div_sel bus cycles while run is
// high; the phase counter is held at zero while run is low so every
// converter-clocked phase starts on a fresh divided period.
module sar_seq_prescaler #(
    parameter int DIV_SEL_W = 2
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 run,
    input  logic [DIV_SEL_W-1:0] div_sel,
    output logic                 tick
);
    localparam int MAX_DIV = 1 << ((1 << DIV_SEL_W) - 1);
    localparam int PRE_W   = (MAX_DIV > 1) ? $clog2(MAX_DIV) : 1;

    logic [PRE_W-1:0] pre;
    logic [PRE_W-1:0] divm1;

    // Terminal count for the selected divisor.
    always_comb divm1 = PRE_W'((32'd1 << div_sel) - 32'd1);

    // Tick when the divided period completes.
    always_comb tick = run && (pre == divm1);

    // Phase counter: cleared when idle or at period end.
    always_ff @(posedge clk) begin
        if (!rst_n)             pre <= '0;
        else if (!run || tick)  pre <= '0;
        else                    pre <= pre + 1'b1;
    end

    p_pre_bound_r8: assert property (@(posedge clk) disable iff (!rst_n)
        run |-> (pre <= divm1));

    p_tick_gap_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (tick && run && $past(run) && (divm1 != '0)) |=> !tick);

endmodule

// File: rtl/sar_seq_avg_tracker.sv
// Averaged-sample counter.
// Loaded with N-1 at the start of each conversion, decremented at the end
// of each non-final sample; last is high while the final sample runs.
module sar_seq_avg_tracker
    import sar_seq_pkg::*;
#(
    parameter int SEL_W   = AVG_SEL_W,
    parameter int MAX_AVG = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic             dec,
    input  logic [SEL_W-1:0] sel,
    output logic             last
);
    localparam int REM_W = $clog2(MAX_AVG);

    logic [REM_W-1:0] rem;

    // Remaining-sample count.
    always_ff @(posedge clk) begin
        if (!rst_n)     rem <= '0;
        else if (load)  rem <= REM_W'(avg_count(sel) - 1);
        else if (dec)   rem <= rem - 1'b1;
    end

    // Final sample flag.
    always_comb last = (rem == '0);

    p_avg_no_underflow_r6: assert property (@(posedge clk) disable iff (!rst_n)
        dec |-> (rem != '0));

    p_load_dec_excl_r6: assert property (@(posedge clk) disable iff (!rst_n)
        !(load && dec));

endmodule

// File: rtl/sar_seq_phase_ctrl.sv
// Phase state machine of the converter sequencer.
// Accepts a start only when idle, captures the configuration, runs the
// bus-clocked and converter-clocked warm-up, then alternates acquire and
// resolve windows. Assumes adck_tick comes from a prescaler that is held
// while adck_run is low.
module sar_seq_phase_ctrl
    import sar_seq_pkg::*;
#(
    parameter int CNT_W       = 6,
    parameter int SU_BUS_CYC  = 5,
    parameter int SU_ADCK_CYC = 5,
    parameter int BASE_SAMPLE = 4,
    parameter int FIRST_ADD   = 2,
    parameter int HS_ADD      = 2,
    parameter int BCT         = 25
) (
    input  logic     clk,
    input  logic     rst_n,
    input  logic     start,
    input  logic     cont_en,
    input  seq_cfg_t cfg_in,
    input  logic     adck_tick,
    input  logic     last_sample,
    output seq_cfg_t cfg_q,
    output logic     adck_run,
    output logic     avg_load,
    output logic     avg_dec,
    output logic     busy,
    output logic     ph_startup,
    output logic     ph_sample,
    output logic     ph_convert,
    output logic     done
);
    localparam int CONV_LEN     = BCT - BASE_SAMPLE;
    localparam int SU_ADCK_PART = SU_ADCK_CYC - FIRST_ADD;

    seq_state_e       state;
    logic [CNT_W-1:0] cnt;
    logic             accept;
    logic             conv_end;

    // Reload value (length minus one) of an acquire window.
    function automatic logic [CNT_W-1:0] samp_reload(input logic first,
                                                     input seq_cfg_t c);
        return CNT_W'(BASE_SAMPLE + (first ? FIRST_ADD : 0)
                      + (c.hs ? HS_ADD : 0) + int'(lsmp_extra(c.lsmp_sel)) - 1);
    endfunction

    // Start acceptance and end-of-conversion events.
    always_comb begin
        accept   = (state == ST_IDLE) && start;
        conv_end = (state == ST_CONVERT) && adck_tick && (cnt == '0);
    end

    // Averaging counter controls.
    always_comb begin
        avg_load = accept || (conv_end && last_sample && cont_en);
        avg_dec  = conv_end && !last_sample;
    end

    // Phase strobes and prescaler enable decoded from state.
    always_comb begin
        busy       = (state != ST_IDLE);
        ph_startup = (state == ST_SU_BUS) || (state == ST_SU_ADCK);
        ph_sample  = (state == ST_SAMPLE);
        ph_convert = (state == ST_CONVERT);
        adck_run   = (state == ST_SU_ADCK) || ph_sample || ph_convert;
    end

    // State, phase counter, captured configuration and done pulse.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state <= ST_IDLE;
            cnt   <= '0;
            cfg_q <= '0;
            done  <= 1'b0;
        end else begin
            done <= 1'b0;
            case (state)
                ST_IDLE: begin
                    if (start) begin
                        cfg_q <= cfg_in;
                        state <= ST_SU_BUS;
                        cnt   <= CNT_W'(SU_BUS_CYC - 1);
                    end
                end
                ST_SU_BUS: begin
                    if (cnt == '0) begin
                        state <= ST_SU_ADCK;
                        cnt   <= CNT_W'(SU_ADCK_PART - 1);
                    end else begin
                        cnt <= cnt - 1'b1;
                    end
                end
                ST_SU_ADCK: begin
                    if (adck_tick) begin
                        if (cnt == '0) begin
                            state <= ST_SAMPLE;
                            cnt   <= samp_reload(1'b1, cfg_q);
                        end else begin
                            cnt <= cnt - 1'b1;
                        end
                    end
                end
                ST_SAMPLE: begin
                    if (adck_tick) begin
                        if (cnt == '0) begin
                            state <= ST_CONVERT;
                            cnt   <= CNT_W'(CONV_LEN - 1);
                        end else begin
                            cnt <= cnt - 1'b1;
                        end
                    end
                end
                ST_CONVERT: begin
                    if (adck_tick) begin
                        if (cnt == '0) begin
                            if (!last_sample) begin
                                state <= ST_SAMPLE;
                                cnt   <= samp_reload(1'b0, cfg_q);
                            end else begin
                                done <= 1'b1;
                                if (cont_en) begin
                                    state <= ST_SAMPLE;
                                    cnt   <= samp_reload(1'b0, cfg_q);
                                end else begin
                                    state <= ST_IDLE;
                                end
                            end
                        end else begin
                            cnt <= cnt - 1'b1;
                        end
                    end
                end
                default: state <= ST_IDLE;
            endcase
        end
    end

    p_start_ignored_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (state != ST_IDLE && state != ST_SU_BUS) |=> (state != ST_SU_BUS));

    p_cfg_held_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (state != ST_IDLE) |=> $stable(cfg_q));

    p_done_next_r10: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (state == ST_IDLE || state == ST_SAMPLE));

    p_done_pulse_r11: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    p_busy_fall_r11: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(busy) |-> done);

    p_strobe_excl_r12: assert property (@(posedge clk) disable iff (!rst_n)
        busy |-> ($countones({ph_startup, ph_sample, ph_convert}) == 1));

endmodule

// File: rtl/sar_conv_sequencer.sv
// Top of the converter phase sequencer.
// Ties the phase state machine to the converter-clock prescaler and the
// averaged-sample counter. Assumes start is a synchronous one-cycle pulse
// and that configuration inputs are valid in the cycle start is high.
module sar_conv_sequencer
    import sar_seq_pkg::*;
#(
    parameter int CNT_W       = 6,
    parameter int SU_BUS_CYC  = 5,
    parameter int SU_ADCK_CYC = 5,
    parameter int BASE_SAMPLE = 4,
    parameter int FIRST_ADD   = 2,
    parameter int HS_ADD      = 2,
    parameter int BCT         = 25,
    parameter int MAX_AVG     = 32
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  start,
    input  logic                  cont_en,
    input  logic                  hs_en,
    input  logic [LSMP_SEL_W-1:0] lsmp_sel,
    input  logic [AVG_SEL_W-1:0]  avg_sel,
    input  logic [DIV_SEL_W-1:0]  div_sel,
    output logic                  busy,
    output logic                  ph_startup,
    output logic                  ph_sample,
    output logic                  ph_convert,
    output logic                  done
);
    seq_cfg_t cfg_in;
    seq_cfg_t cfg_q;
    logic     adck_run;
    logic     adck_tick;
    logic     avg_load;
    logic     avg_dec;
    logic     last_sample;

    // Bundle the configuration inputs for capture at start.
    always_comb begin
        cfg_in.hs       = hs_en;
        cfg_in.lsmp_sel = lsmp_sel;
        cfg_in.avg_sel  = avg_sel;
        cfg_in.div_sel  = div_sel;
    end

    sar_seq_phase_ctrl #(
        .CNT_W       (CNT_W),
        .SU_BUS_CYC  (SU_BUS_CYC),
        .SU_ADCK_CYC (SU_ADCK_CYC),
        .BASE_SAMPLE (BASE_SAMPLE),
        .FIRST_ADD   (FIRST_ADD),
        .HS_ADD      (HS_ADD),
        .BCT         (BCT)
    ) u_ctrl (
        .clk         (clk),
        .rst_n       (rst_n),
        .start       (start),
        .cont_en     (cont_en),
        .cfg_in      (cfg_in),
        .adck_tick   (adck_tick),
        .last_sample (last_sample),
        .cfg_q       (cfg_q),
        .adck_run    (adck_run),
        .avg_load    (avg_load),
        .avg_dec     (avg_dec),
        .busy        (busy),
        .ph_startup  (ph_startup),
        .ph_sample   (ph_sample),
        .ph_convert  (ph_convert),
        .done        (done)
    );

    sar_seq_prescaler #(
        .DIV_SEL_W (DIV_SEL_W)
    ) u_div (
        .clk     (clk),
        .rst_n   (rst_n),
        .run     (adck_run),
        .div_sel (cfg_q.div_sel),
        .tick    (adck_tick)
    );

    sar_seq_avg_tracker #(
        .SEL_W   (AVG_SEL_W),
        .MAX_AVG (MAX_AVG)
    ) u_avg (
        .clk   (clk),
        .rst_n (rst_n),
        .load  (avg_load),
        .dec   (avg_dec),
        .sel   (avg_load ? avg_sel_src() : cfg_q.avg_sel),
        .last  (last_sample)
    );

    // Averaging code to load: the live input on a fresh start, else the
    // captured value for continuous restarts.
    function automatic logic [AVG_SEL_W-1:0] avg_sel_src();
        return busy ? cfg_q.avg_sel : avg_sel;
    endfunction

endmodule

// File: tb/sar_conv_sequencer_test.sv
// Self-checking bench: sweeps single-conversion timing over divisor,
// high-speed and extended-acquire codes, then averaging codes, then
// directed start-while-busy and continuous-run cases.
module sar_conv_sequencer_test;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       start = 1'b0;
    logic       cont_en = 1'b0;
    logic       hs_en = 1'b0;
    logic [2:0] lsmp_sel = '0;
    logic [2:0] avg_sel = '0;
    logic [1:0] div_sel = '0;
    logic       busy, ph_startup, ph_sample, ph_convert, done;

    int n_checks = 0;
    int n_errors = 0;

    always #10 clk = ~clk;

    sar_conv_sequencer uut (
        .clk        (clk),
        .rst_n      (rst_n),
        .start      (start),
        .cont_en    (cont_en),
        .hs_en      (hs_en),
        .lsmp_sel   (lsmp_sel),
        .avg_sel    (avg_sel),
        .div_sel    (div_sel),
        .busy       (busy),
        .ph_startup (ph_startup),
        .ph_sample  (ph_sample),
        .ph_convert (ph_convert),
        .done       (done)
    );

    task automatic check(input bit ok, input string req, input int act, input int exp);
        n_checks++;
        if (!ok) begin
            n_errors++;
            $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    function automatic int l_of(input int code);
        case (code)
            0: return 0;
            1: return 2;
            2: return 6;
            3: return 12;
            default: return 20;
        endcase
    endfunction

    function automatic int n_of(input int code);
        case (code)
            0: return 1;
            1: return 4;
            2: return 8;
            3: return 16;
            default: return 32;
        endcase
    endfunction

    // One single conversion; extra_at>0 pulses start again at that cycle.
    task automatic run_conv(input int dv, input int hs, input int ls, input int av,
                            input int extra_at);
        int t_busy = 0, t_su = 0, t_first = 0, t_samp = 0, t_conv = 0;
        int bad_excl = 0, early_done = 0, cyc = 1;
        bit conv_seen = 0;
        int d = 1 << dv;
        int h = hs ? 2 : 0;
        int l = l_of(ls);
        int n = n_of(av);
        @(negedge clk);
        div_sel  = dv[1:0];
        hs_en    = hs[0];
        lsmp_sel = ls[2:0];
        avg_sel  = av[2:0];
        cont_en  = 1'b0;
        start    = 1'b1;
        @(negedge clk);
        start = 1'b0;
        while (!done && cyc < 20000) begin
            if (busy) t_busy++;
            if (ph_startup) t_su++;
            if (ph_sample) begin
                t_samp++;
                if (!conv_seen) t_first++;
            end
            if (ph_convert) begin
                t_conv++;
                conv_seen = 1;
            end
            if (busy && (int'(ph_startup) + int'(ph_sample) + int'(ph_convert) != 1)) bad_excl++;
            if (!busy && (ph_startup || ph_sample || ph_convert)) bad_excl++;
            start = (cyc == extra_at);
            cyc++;
            @(negedge clk);
            if (done && ph_sample) early_done++;
        end
        start = 1'b0;
        // R2 total busy time; R8 divisor scaling shows through D
        check(t_busy == 5 + d * (5 + n * (25 + h + l)), "R2 busy length", t_busy,
              5 + d * (5 + n * (25 + h + l)));
        // R7 warm-up once per sequence
        check(t_su == 5 + 3 * d, "R7 warm-up length", t_su, 5 + 3 * d);
        // R3 first acquire window, R4 / R5 adders
        check(t_first == d * (6 + h + l), "R3 first acquire", t_first, d * (6 + h + l));
        check(t_samp == d * (6 + h + l + (n - 1) * (4 + h + l)), "R5 total acquire",
              t_samp, d * (6 + h + l + (n - 1) * (4 + h + l)));
        // R7 resolve length, R6 sample count
        check(t_conv == 21 * d * n, "R6 total resolve", t_conv, 21 * d * n);
        check(bad_excl == 0, "R12 strobe exclusivity", bad_excl, 0);
        // R11 done ends run with busy low
        check(done && !busy, "R11 done with busy low", int'(busy), 0);
        @(negedge clk);
        check(!done && !busy, "R11 done single pulse", int'(done), 0);
    endtask

    initial begin
        repeat (190000) @(posedge clk);
        n_checks++;
        n_errors++;
        $display("FAIL watchdog: actual=%0d expected=%0d", 1, 0);
        $display("  Result: errors=%0d of %0d checks", n_errors, n_checks);
        $finish;
    end

    initial begin
        int dd0, dd1, dd2, nd, cyc, su_after, samp_between, busy_d0, busy_d1, busy_d2;
        // R1 reset state
        repeat (3) @(negedge clk);
        check(!busy && !done && !ph_startup && !ph_sample && !ph_convert,
              "R1 outputs in reset", int'(busy), 0);
        rst_n = 1'b1;
        repeat (3) @(negedge clk);
        check(!busy && !done && !ph_startup && !ph_sample && !ph_convert,
              "R1 outputs idle after reset", int'(busy), 0);

        // Sweep R4 R5 R8 single conversions
        for (int dv = 0; dv < 4; dv++)
            for (int hs = 0; hs < 2; hs++)
                for (int ls = 0; ls < 6; ls++)
                    run_conv(dv, hs, ls, 0, 0);

        // Sweep R6 averaging codes, including aliases 5..7
        for (int av = 0; av < 8; av++)
            run_conv(0, 0, 0, av, 0);
        run_conv(1, 1, 3, 1, 0);

        // R9 start while busy is ignored
        run_conv(0, 0, 0, 0, 10);
        begin
            int seen = 0;
            for (int i = 0; i < 6; i++) begin
                @(negedge clk);
                if (busy) seen++;
            end
            check(seen == 0, "R9 no queued conversion", seen, 0);
        end

        // R10 continuous run, ended by dropping cont_en
        @(negedge clk);
        div_sel = 2'd0; hs_en = 1'b0; lsmp_sel = 3'd0; avg_sel = 3'd0;
        cont_en = 1'b1;
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        nd = 0; cyc = 1; su_after = 0; samp_between = 0;
        dd0 = 0; dd1 = 0; dd2 = 0; busy_d0 = 0; busy_d1 = 0; busy_d2 = 1;
        while (nd < 3 && cyc < 1000) begin
            if (done) begin
                if (nd == 0) begin dd0 = cyc; busy_d0 = int'(busy); end
                if (nd == 1) begin dd1 = cyc; busy_d1 = int'(busy); end
                if (nd == 2) begin dd2 = cyc; busy_d2 = int'(busy); end
                nd++;
                if (nd == 2) cont_en = 1'b0;
            end
            if (nd >= 1 && ph_startup) su_after++;
            if (nd == 1 && ph_sample) samp_between++;
            cyc++;
            if (nd < 3) @(negedge clk);
        end
        check(dd0 == 36, "R10 first done cycle", dd0, 36);
        check(busy_d0 == 1, "R10 busy kept at first done", busy_d0, 1);
        check(dd1 - dd0 == 25, "R10 back-to-back period", dd1 - dd0, 25);
        check(su_after == 0, "R10 no warm-up when continuing", su_after, 0);
        check(samp_between == 4, "R3 later acquire window", samp_between, 4);
        check(busy_d1 == 1, "R10 busy at second done", busy_d1, 1);
        check(dd2 - dd1 == 25, "R10 final conversion period", dd2 - dd1, 25);
        check(busy_d2 == 0, "R11 busy falls with final done", busy_d2, 0);
        @(negedge clk);
        check(!busy && !done, "R10 run stopped", int'(busy), 0);

        $display("  Result: errors=%0d of %0d checks", n_errors, n_checks);
        $finish;
    end

endmodule